// File: doc/BRIEF.md
# Twelve-Channel DMA Service Arbiter with Fixed and Rotating Classes

This block decides which DMA channel is serviced next. Every channel belongs to one of two classes: a fixed class, where the lowest-numbered requester is always preferred, or a rotating class, where requesters take turns. Requesters in the fixed class always beat requesters in the rotating class. Only a channel that is both enabled and requesting can be chosen.

Software moves channels between classes through two write ports. One port only sets class bits and the other only clears them, so a channel's class can change without a read-modify-write of the whole vector. The class vector is returned on a read-back port. The arbiter registers its choice as a one-hot grant with a valid flag. It holds that grant until the transfer engine returns an accept strobe. It then drops valid for one cycle, in which it arbitrates again.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, `gnt_valid` is 0, `gnt` is all zeros, every class bit reads 0 (all channels rotating), and the rotating search begins at channel 0.
- R2: A cycle with `cls_set_we` high sets to 1 the class bit of every channel whose `cls_set_data` bit is 1, visible on `cls_rdata` the next cycle. Bits written as 0 keep their value.
- R3: A cycle with `cls_clr_we` high clears to 0 the class bit of every channel whose `cls_clr_data` bit is 1. Bits written as 0 keep their value. If the same channel is set and cleared in the same cycle, the set wins and the bit becomes 1.
- R4: `cls_rdata[i]` always shows the current class of channel i: 1 means fixed class, 0 means rotating class.
- R5: A channel whose `chan_en` bit is 0 is never granted, even when its `chan_req` bit is 1.
- R6: When the arbiter is idle and any enabled, requesting channel is in the fixed class, the grant goes to the lowest-numbered such channel, ahead of every rotating-class requester.
- R7: With no fixed-class candidate, the grant goes to the first enabled, requesting rotating-class channel found by searching upward from the channel after the last accepted rotating grant, wrapping from channel 11 to channel 0.
- R8: The rotating search position moves only when a grant to a rotating-class channel is accepted. Accepting a fixed-class grant leaves it unchanged.
- R9: While `gnt_valid` is 1, `gnt` has exactly one bit set and stays unchanged until a cycle with `accept` high. While `gnt_valid` is 0, `gnt` is all zeros. Changes to requests, enables or classes do not alter a held grant.
- R10: In an idle cycle with at least one candidate, the grant appears at the next clock edge. A cycle with `accept` high while valid makes `gnt_valid` 0 in the next cycle. `accept` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_set_we | input | 1 | Write strobe of the class-set port |
| cls_set_data | input | 12 | Channels to move into the fixed class |
| cls_clr_we | input | 1 | Write strobe of the class-clear port |
| cls_clr_data | input | 12 | Channels to move into the rotating class |
| cls_rdata | output | 12 | Current class bits (1 = fixed) |
| chan_en | input | 12 | Per-channel enable |
| chan_req | input | 12 | Per-channel service request |
| accept | input | 1 | Transfer engine accepted/finished the current grant |
| gnt | output | 12 | One-hot granted channel |
| gnt_valid | output | 1 | A grant is being presented |

## Verification
A corrupted class bit is visible on `cls_rdata` in the cycle after the faulty write. It also misroutes the next grant in which that channel competes. A wrong rotating position stays hidden until two or more rotating requesters compete. It then shows as an out-of-turn grant one cycle after the arbiter goes idle. A grant that drifts or drops before accept is visible on `gnt` in the cycle it happens. The bench therefore compares the ports every cycle. It uses request patterns that make a wrongly moved pointer pick a different channel from the correct one.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  parameter int unsigned ARB_CH_DEFAULT = 12;

  // Index that follows idx in a ring of n positions.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Index reached by stepping k places forward from idx in a ring of n.
  function automatic int unsigned ring_step(input int unsigned idx, input int unsigned k,
                                            input int unsigned n);
    int unsigned s;
    s = idx + k;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/dma_arb_class_reg.sv
module dma_arb_class_reg #(
  parameter int unsigned NCH = dma_arb_pkg::ARB_CH_DEFAULT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_we,
  input  logic [NCH-1:0] set_bits,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_bits,
  output logic [NCH-1:0] cls
);
  logic [NCH-1:0] set_mask;
  logic [NCH-1:0] clr_mask;
  logic [NCH-1:0] cls_next;

  assign set_mask = set_we ? set_bits : '0;
  assign clr_mask = clr_we ? clr_bits : '0;
  // set has precedence over clear on the same bit
  assign cls_next = (cls & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cls <= '0;
    else        cls <= cls_next;
  end
endmodule

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick #(
  parameter int unsigned NCH = dma_arb_pkg::ARB_CH_DEFAULT,
  parameter int unsigned IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] cand,
  output logic           hit,
  output logic [IW-1:0]  idx
);
  function automatic logic [IW-1:0] lowest_set(input logic [NCH-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign hit = |cand;
  assign idx = lowest_set(cand);
endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
  parameter int unsigned NCH = dma_arb_pkg::ARB_CH_DEFAULT,
  parameter int unsigned IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] cand,
  input  logic [IW-1:0]  last,
  output logic           hit,
  output logic [IW-1:0]  idx
);
  // First candidate strictly after 'last', going round the ring.
  function automatic logic [IW-1:0] search_after(input logic [NCH-1:0] v,
                                                 input logic [IW-1:0] l);
    logic [IW-1:0] r;
    logic          found;
    int unsigned   pos;
    r     = '0;
    found = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      pos = dma_arb_pkg::ring_step(int'(l), k, NCH);
      if (!found && v[pos]) begin
        r     = IW'(pos);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  assign hit = |cand;
  assign idx = search_after(cand, last);
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int unsigned NCH = dma_arb_pkg::ARB_CH_DEFAULT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cls_set_we,
  input  logic [NCH-1:0] cls_set_data,
  input  logic           cls_clr_we,
  input  logic [NCH-1:0] cls_clr_data,
  output logic [NCH-1:0] cls_rdata,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] chan_req,
  input  logic           accept,
  output logic [NCH-1:0] gnt,
  output logic           gnt_valid
);
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [IW-1:0] PTR_RESET = IW'(NCH - 1);

  logic [NCH-1:0] cls_q;
  logic [NCH-1:0] eligible;
  logic [NCH-1:0] fix_cand;
  logic [NCH-1:0] rr_cand;
  logic           fix_hit, rr_hit;
  logic [IW-1:0]  fix_idx, rr_idx;

  logic           valid_q;
  logic [IW-1:0]  gidx_q;
  logic           gfix_q;
  logic [IW-1:0]  rr_last_q;

  // named internal events, observed by the checker
  logic           launch;
  logic           retire;
  logic           rr_advance;
  logic [IW-1:0]  pick_idx;

  dma_arb_class_reg #(.NCH(NCH)) u_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (cls_set_we),
    .set_bits (cls_set_data),
    .clr_we   (cls_clr_we),
    .clr_bits (cls_clr_data),
    .cls      (cls_q)
  );

  assign eligible = chan_en & chan_req;
  assign fix_cand = eligible & cls_q;
  assign rr_cand  = eligible & ~cls_q;

  dma_arb_fixed_pick #(.NCH(NCH), .IW(IW)) u_fix (
    .cand (fix_cand),
    .hit  (fix_hit),
    .idx  (fix_idx)
  );

  dma_arb_rr_pick #(.NCH(NCH), .IW(IW)) u_rr (
    .cand (rr_cand),
    .last (rr_last_q),
    .hit  (rr_hit),
    .idx  (rr_idx)
  );

  assign pick_idx   = fix_hit ? fix_idx : rr_idx;
  assign launch     = !valid_q && (fix_hit || rr_hit);
  assign retire     = valid_q && accept;
  assign rr_advance = retire && !gfix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      gidx_q    <= '0;
      gfix_q    <= 1'b0;
      rr_last_q <= PTR_RESET;
    end else begin
      if (retire) begin
        valid_q <= 1'b0;
      end else if (launch) begin
        valid_q <= 1'b1;
        gidx_q  <= pick_idx;
        gfix_q  <= fix_hit;
      end
      if (rr_advance) rr_last_q <= gidx_q;
    end
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_onehot
      assign gnt[i] = valid_q && (gidx_q == IW'(i));
    end
  endgenerate

  assign gnt_valid = valid_q;
  assign cls_rdata = cls_q;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int unsigned NCH = dma_arb_pkg::ARB_CH_DEFAULT,
  parameter int unsigned IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cls_set_we,
  input logic [NCH-1:0] cls_set_data,
  input logic           cls_clr_we,
  input logic [NCH-1:0] cls_rdata,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] chan_req,
  input logic           accept,
  input logic [NCH-1:0] gnt,
  input logic           gnt_valid,
  input logic           rr_advance,
  input logic [IW-1:0]  rr_last_q
);
  assert_gnt_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid ? ($countones(gnt) == 1) : (gnt == '0));

  assert_gnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !accept) |=> (gnt_valid && $stable(gnt)));

  assert_retire_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && accept) |=> !gnt_valid);

  assert_enabled_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |=> (!gnt_valid || ((gnt & $past(chan_en & chan_req)) != '0)));

  assert_fixed_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && ((chan_en & chan_req & cls_rdata) != '0))
      |=> (gnt_valid && ((gnt & $past(cls_rdata)) != '0)));

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cls_set_we |=> ((cls_rdata & $past(cls_set_data)) == $past(cls_set_data)));

  assert_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cls_set_we && !cls_clr_we) |=> $stable(cls_rdata));

  assert_ptr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_advance |=> $stable(rr_last_q));
endmodule

bind dma_chan_arbiter dma_arb_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cls_set_we   (cls_set_we),
  .cls_set_data (cls_set_data),
  .cls_clr_we   (cls_clr_we),
  .cls_rdata    (cls_rdata),
  .chan_en      (chan_en),
  .chan_req     (chan_req),
  .accept       (accept),
  .gnt          (gnt),
  .gnt_valid    (gnt_valid),
  .rr_advance   (rr_advance),
  .rr_last_q    (rr_last_q)
);

// File: tb/tb_dma_chan_arbiter.sv
module tb_dma_chan_arbiter;
  localparam int N = 12;
  localparam time HALF = 4ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cls_set_we = 1'b0, cls_clr_we = 1'b0, accept = 1'b0;
  logic [N-1:0] cls_set_data = '0, cls_clr_data = '0, chan_en = '0, chan_req = '0;
  logic [N-1:0] cls_rdata, gnt;
  logic         gnt_valid;

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string cur = "R1";

  // behavioural reference state
  bit m_cls [N];
  bit m_val, m_gfix;
  int m_g, m_last;

  always #HALF clk = ~clk;

  dma_chan_arbiter #(.NCH(N)) dut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cls[i]) m_cls[i] = 1'b0;
      m_val = 0; m_gfix = 0; m_g = 0; m_last = N - 1;
    end else begin
      int pick;
      pick = -1;
      if (m_val) begin
        if (accept) begin
          m_val = 0;
          if (!m_gfix) m_last = m_g;
        end
      end else begin
        for (int i = 0; i < N; i++)
          if (pick < 0 && chan_en[i] && chan_req[i] && m_cls[i]) begin pick = i; m_gfix = 1; end
        if (pick < 0)
          for (int k = 1; k <= N; k++) begin
            int c;
            c = (m_last + k) % N;
            if (pick < 0 && chan_en[c] && chan_req[c] && !m_cls[c]) begin pick = c; m_gfix = 0; end
          end
        if (pick >= 0) begin m_val = 1; m_g = pick; end
      end
      for (int i = 0; i < N; i++) begin
        if (cls_clr_we && cls_clr_data[i]) m_cls[i] = 1'b0;
        if (cls_set_we && cls_set_data[i]) m_cls[i] = 1'b1;
      end
    end
  end

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [N-1:0] eg, ec;
    eg = m_val ? (N'(1) << m_g) : '0;
    for (int i = 0; i < N; i++) ec[i] = m_cls[i];
    chk({gnt[N-1:1], gnt[0] ^ 1'b0}, eg, {cur, " grant"});
    chk({{(N-1){1'b0}}, gnt_valid}, {{(N-1){1'b0}}, m_val}, {cur, " valid"});
    chk(cls_rdata, ec, {cur, " class"});
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic acc_pulse();
    accept = 1'b1; tick(); accept = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    cur = "R1";
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk(gnt, '0, "R1 grant after reset");
    chk(cls_rdata, '0, "R1 class after reset");

    cur = "R5";
    chan_en = '0; chan_req = '1;
    tick(); tick(); tick();
    chk({{(N-1){1'b0}}, gnt_valid}, '0, "R5 disabled requesters");
    chan_en = 12'hFFF ^ 12'h020; chan_req = 12'h020;
    tick(); tick();
    chk({{(N-1){1'b0}}, gnt_valid}, '0, "R5 channel 5 disabled");

    cur = "R7";
    chan_en = '1; chan_req = 12'h088;
    tick();
    chk(gnt, 12'h008, "R7 first rotating grant from channel 0");
    cur = "R10";
    acc_pulse();
    chk({{(N-1){1'b0}}, gnt_valid}, '0, "R10 idle after accept");
    cur = "R7";
    tick();
    chk(gnt, 12'h080, "R7 next after 3");
    acc_pulse(); tick();
    chk(gnt, 12'h008, "R7 wraps back to 3");
    chan_req = 12'h801;
    acc_pulse(); tick();
    chk(gnt, 12'h800, "R7 channel 11 after 3");
    acc_pulse(); tick();
    chk(gnt, 12'h001, "R7 wrap from 11 to 0");
    chan_req = '0;
    acc_pulse();

    cur = "R2";
    cls_set_we = 1'b1; cls_set_data = 12'h200; tick(); cls_set_we = 1'b0;
    chk(cls_rdata, 12'h200, "R2 set channel 9");
    cur = "R6";
    chan_req = 12'h604;
    tick();
    chk(gnt, 12'h200, "R6 fixed beats rotating");
    cls_set_we = 1'b1; cls_set_data = 12'h800;
    acc_pulse(); cls_set_we = 1'b0;
    cur = "R4";
    chk(cls_rdata, 12'hA00, "R4 readback both fixed");
    cur = "R6";
    chan_req = 12'hA04;
    tick();
    chk(gnt, 12'h200, "R6 lowest fixed wins");
    acc_pulse();
    cur = "R8";
    chan_req = 12'h420;
    tick();
    chk(gnt, 12'h020, "R8 pointer unmoved by fixed grants");

    cur = "R9";
    chan_req = 12'h200;
    for (int t = 0; t < 4; t++) begin
      tick();
      chk(gnt, 12'h020, "R9 grant held");
    end
    acc_pulse(); tick();
    chk(gnt, 12'h200, "R9 new grant after release");
    chan_req = '0;
    acc_pulse();

    cur = "R3";
    cls_clr_we = 1'b1; cls_clr_data = '0; tick(); cls_clr_we = 1'b0;
    chk(cls_rdata, 12'hA00, "R3 clear with zeros");
    cls_clr_we = 1'b1; cls_clr_data = 12'h200; cls_set_we = 1'b1; cls_set_data = 12'h200;
    tick(); cls_clr_we = 1'b0; cls_set_we = 1'b0;
    chk(cls_rdata, 12'hA00, "R3 set wins over clear");
    cls_clr_we = 1'b1; cls_clr_data = 12'h800; tick(); cls_clr_we = 1'b0;
    chk(cls_rdata, 12'h200, "R3 clear channel 11");
    cur = "R2";
    cls_set_we = 1'b1; cls_set_data = '0; tick(); cls_set_we = 1'b0;
    chk(cls_rdata, 12'h200, "R2 set with zeros");
    cur = "R10";
    accept = 1'b1; tick(); tick(); accept = 1'b0;
    chk({{(N-1){1'b0}}, gnt_valid}, '0, "R10 accept while idle");

    cur = "R9";
    lfsr = 16'hACE1;
    for (int t = 0; t < 600; t++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      chan_req     = lfsr[11:0] ^ {lfsr[3:0], lfsr[15:8]};
      chan_en      = ~{lfsr[0], lfsr[5], lfsr[9], 9'b0};
      accept       = lfsr[14] | lfsr[2];
      cls_set_we   = (lfsr[7:5] == 3'b101);
      cls_set_data = N'(1) << (lfsr[11:8] % 12);
      cls_clr_we   = (lfsr[4:2] == 3'b011);
      cls_clr_data = {lfsr[12:9], lfsr[7:0]};
      tick();
    end
    accept = 1'b0; cls_set_we = 1'b0; cls_clr_we = 1'b0;
    tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule